// File: doc/BRIEF.md
# Interval Timer with Count Capture

This block is a 32-bit down-counting interval timer placed behind a small word-addressed register bus. Software sets the interval by writing the period as two 16-bit halves. It starts and stops the counter with strobe bits in the control word, and it picks either one-shot or free-running reload. When the count passes through zero, the timer raises a sticky timeout flag. The flag, gated by an interrupt-enable bit, drives a level interrupt.

The live count cannot be read directly. A write to either capture slot copies the whole 32-bit count into two holding registers, and software then reads them one half at a time without the two halves tearing. The counter steps once per core clock. Reads have no side effects and return data combinationally from the addressed slot. Writes take effect at the rising clock edge of the cycle in which `reg_wr` is high.

Top module: `ivl_timer`

## Requirements
- R1: The slot is the byte address shifted right by two, and the low two address bits are ignored. Slot 0 is status, 1 is control, 2 is period low, 3 is period high, 4 is capture low and 5 is capture high. Slots 6 and above read as zero, and writes to them change nothing.
- R2: After reset every slot reads zero, `irq` is low, the timer is stopped, and the count holds all ones (0xFFFFFFFF).
- R3: Control bits: bit 0 is interrupt enable, bit 1 is free-running mode, bit 2 is the start strobe and bit 3 is the stop strobe. A read of control returns only bits 0 and 1. The strobe bits and all upper bits read as zero.
- R4: Status bits: bit 0 is the timeout flag and bit 1 is the running flag. Any write to status clears the timeout flag, whatever the data. A timeout in the same cycle takes precedence and leaves the flag set.
- R5: A start strobe sets the running flag only when the timer is stopped, and counting begins on the next cycle. A start strobe while the timer is running changes neither the count nor the flags.
- R6: A stop strobe clears the running flag when the timer is running, and the count freezes after that cycle's step. If start and stop are both set in one write, stop wins.
- R7: Each period slot keeps only the low 16 bits of the written data. A write to either half stops the timer and loads the count with the new 32-bit period {high, low}.
- R8: While running, the count falls by one each clock. The cycle in which the count is zero is the timeout, so one interval lasts period+1 cycles.
- R9: In free-running mode, a timeout sets the timeout flag, reloads the count from the period, and keeps the timer running.
- R10: In one-shot mode, a timeout sets the timeout flag, clears the running flag, and leaves the count holding the period value.
- R11: A write to either capture slot copies the count, as it stood in that write cycle, into both capture registers (bits 15:0 to low, bits 31:16 to high).
- R12: `irq` is high exactly when the timeout flag and the interrupt-enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the counter steps on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the addressed slot |
| reg_addr | input | ADDR_W | Byte address; bits above 1 select the slot |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Combinational read data of the addressed slot |
| irq | output | 1 | Level interrupt: timeout flag AND interrupt enable |

## Verification
A write committed at rising edge E shows up in the flags, the count and `irq` immediately after E. A read has no latency, so the bench drives and reads at falling edges, half a cycle away from any update. A capture committed at edge E+1+w after a start at edge E holds the count after w steps. A status read made just after that capture sees the state after w+1 steps. The bench's expected-value functions take those two step counts separately. Same-edge collisions are placed on exact cycles by counting idle cycles from the start write: a status clear against a timeout, a stop against the last step, and a period write against a running count.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    localparam int HALF_W    = 16;
    localparam int CNT_W     = 2 * HALF_W;
    localparam int NUM_SLOTS = 6;

    typedef enum logic [2:0] {
        SLOT_STAT   = 3'd0,
        SLOT_CTRL   = 3'd1,
        SLOT_PER_LO = 3'd2,
        SLOT_PER_HI = 3'd3,
        SLOT_CAP_LO = 3'd4,
        SLOT_CAP_HI = 3'd5
    } slot_e;

    localparam int ST_TO    = 0;
    localparam int ST_RUN   = 1;
    localparam int CT_IE    = 0;
    localparam int CT_CONT  = 1;
    localparam int CT_START = 2;
    localparam int CT_STOP  = 3;

    typedef struct packed {
        logic              stat_wr;
        logic              ctrl_wr;
        logic              per_lo_wr;
        logic              per_hi_wr;
        logic              cap_wr;
        logic              ie;
        logic              cont;
        logic              start;
        logic              stop;
        logic [HALF_W-1:0] half;
    } wr_cmd_t;

endpackage

// File: rtl/ivl_timer_wdec.sv
module ivl_timer_wdec
    import ivl_timer_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BUS_W  = 32
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output wr_cmd_t           cmd_o,
    output slot_e             slot_o,
    output logic              in_map_o
);

    localparam int SLOT_W = ADDR_W - 2;

    logic [SLOT_W-1:0] slot_raw;
    logic              in_map;
    slot_e             slot;
    logic              unused_bits;

    assign slot_raw    = addr_i[ADDR_W-1:2];
    assign in_map      = (slot_raw < SLOT_W'(NUM_SLOTS));
    assign slot        = slot_e'(slot_raw[2:0]);
    assign unused_bits = ^{addr_i[1:0], wdata_i[BUS_W-1:HALF_W]};

    always_comb begin
        cmd_o       = '0;
        cmd_o.ie    = wdata_i[CT_IE];
        cmd_o.cont  = wdata_i[CT_CONT];
        cmd_o.start = wdata_i[CT_START];
        cmd_o.stop  = wdata_i[CT_STOP];
        cmd_o.half  = wdata_i[HALF_W-1:0];
        if (wr_i && in_map) begin
            case (slot)
                SLOT_STAT:   cmd_o.stat_wr   = 1'b1;
                SLOT_CTRL:   cmd_o.ctrl_wr   = 1'b1;
                SLOT_PER_LO: cmd_o.per_lo_wr = 1'b1;
                SLOT_PER_HI: cmd_o.per_hi_wr = 1'b1;
                SLOT_CAP_LO,
                SLOT_CAP_HI: cmd_o.cap_wr    = 1'b1;
                default:     ;
            endcase
        end
    end

    assign slot_o   = slot;
    assign in_map_o = in_map;

endmodule

// File: rtl/ivl_timer_core.sv
module ivl_timer_core
    import ivl_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wr_cmd_t          cmd_i,
    input  logic             cont_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] period_nxt_i,
    output logic [CNT_W-1:0] count_o,
    output logic             to_o,
    output logic             run_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             to;
        logic             run;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     per_wr;
    logic     hit;

    assign per_wr = cmd_i.per_lo_wr | cmd_i.per_hi_wr;
    assign hit    = st_q.run && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (cmd_i.stat_wr) begin
            st_d.to = 1'b0;
        end
        if (st_q.run) begin
            if (hit) begin
                st_d.cnt = period_i;
                st_d.to  = 1'b1;
                if (!cont_i) begin
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (cmd_i.ctrl_wr) begin
            if (cmd_i.stop) begin
                st_d.run = 1'b0;
            end else if (cmd_i.start && !st_q.run) begin
                st_d.run = 1'b1;
            end
        end
        if (per_wr) begin
            st_d.run = 1'b0;
            st_d.cnt = period_nxt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
            st_q.to  <= 1'b0;
            st_q.run <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign to_o    = st_q.to;
    assign run_o   = st_q.run;

    // R4: a status write without a coincident timeout leaves the flag clear
    a_r4_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.stat_wr && !hit |=> !st_q.to);

    // R5: start from the stopped state sets the running flag
    a_r5_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.ctrl_wr && cmd_i.start && !cmd_i.stop && !st_q.run |=> st_q.run);

    // R6: a stop strobe always leaves the timer stopped
    a_r6_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.ctrl_wr && cmd_i.stop |=> !st_q.run);

    // R7: a period write stops the timer and loads the new period
    a_r7_period_loads: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |=> !st_q.run && (st_q.cnt == $past(period_nxt_i)));

    // R8: one step per clock while running and away from zero
    a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run && (st_q.cnt != '0) && !per_wr |=> st_q.cnt == $past(st_q.cnt) - 1'b1);

    // R8: a stopped timer keeps its count unless a period is written
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run && !per_wr |=> $stable(st_q.cnt));

    // R9: free-running timeout reloads and keeps running
    a_r9_cont_reload: assert property (@(posedge clk) disable iff (!rst_n)
        hit && cont_i && !per_wr && !(cmd_i.ctrl_wr && cmd_i.stop)
        |=> st_q.run && st_q.to && (st_q.cnt == $past(period_i)));

    // R10: one-shot timeout stops and holds the period value
    a_r10_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !cont_i && !per_wr
        |=> !st_q.run && st_q.to && (st_q.cnt == $past(period_i)));

endmodule

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs
    import ivl_timer_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_cmd_t          cmd_i,
    input  slot_e            slot_i,
    input  logic             in_map_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             to_i,
    input  logic             run_i,
    output logic             ie_o,
    output logic             cont_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] period_nxt_o,
    output logic [BUS_W-1:0] rdata_o
);

    typedef struct packed {
        logic              ie;
        logic              cont;
        logic [HALF_W-1:0] per_lo;
        logic [HALF_W-1:0] per_hi;
        logic [HALF_W-1:0] cap_lo;
        logic [HALF_W-1:0] cap_hi;
    } reg_st_t;

    reg_st_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (cmd_i.ctrl_wr) begin
            rg_d.ie   = cmd_i.ie;
            rg_d.cont = cmd_i.cont;
        end
        if (cmd_i.per_lo_wr) begin
            rg_d.per_lo = cmd_i.half;
        end
        if (cmd_i.per_hi_wr) begin
            rg_d.per_hi = cmd_i.half;
        end
        if (cmd_i.cap_wr) begin
            rg_d.cap_lo = count_i[HALF_W-1:0];
            rg_d.cap_hi = count_i[CNT_W-1:HALF_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (in_map_i) begin
            case (slot_i)
                SLOT_STAT: begin
                    rdata_o[ST_TO]  = to_i;
                    rdata_o[ST_RUN] = run_i;
                end
                SLOT_CTRL: begin
                    rdata_o[CT_IE]   = rg_q.ie;
                    rdata_o[CT_CONT] = rg_q.cont;
                end
                SLOT_PER_LO: rdata_o[HALF_W-1:0] = rg_q.per_lo;
                SLOT_PER_HI: rdata_o[HALF_W-1:0] = rg_q.per_hi;
                SLOT_CAP_LO: rdata_o[HALF_W-1:0] = rg_q.cap_lo;
                SLOT_CAP_HI: rdata_o[HALF_W-1:0] = rg_q.cap_hi;
                default:     rdata_o = '0;
            endcase
        end
    end

    assign ie_o         = rg_q.ie;
    assign cont_o       = rg_q.cont;
    assign period_o     = {rg_q.per_hi, rg_q.per_lo};
    assign period_nxt_o = {rg_d.per_hi, rg_d.per_lo};

    // R11: a capture write holds the count seen in the write cycle
    a_r11_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.cap_wr |=> {rg_q.cap_hi, rg_q.cap_lo} == $past(count_i));

    // R7: only the low half of the data lands in a period slot
    a_r7_period_half: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.per_lo_wr |=> rg_q.per_lo == $past(cmd_i.half));

    // R3: control readback never shows strobe or upper bits
    a_r3_ctrl_read: assert property (@(posedge clk) disable iff (!rst_n)
        in_map_i && (slot_i == SLOT_CTRL) |-> rdata_o[BUS_W-1:2] == '0);

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              irq
);

    wr_cmd_t          cmd;
    slot_e            slot;
    logic             in_map;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] period_nxt;
    logic             to_flag;
    logic             run_flag;
    logic             ie;
    logic             cont;

    ivl_timer_wdec #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_wdec (
        .wr_i     (reg_wr),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .cmd_o    (cmd),
        .slot_o   (slot),
        .in_map_o (in_map)
    );

    ivl_timer_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd),
        .cont_i       (cont),
        .period_i     (period),
        .period_nxt_i (period_nxt),
        .count_o      (count),
        .to_o         (to_flag),
        .run_o        (run_flag)
    );

    ivl_timer_regs #(.BUS_W(BUS_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd),
        .slot_i       (slot),
        .in_map_i     (in_map),
        .count_i      (count),
        .to_i         (to_flag),
        .run_i        (run_flag),
        .ie_o         (ie),
        .cont_o       (cont),
        .period_o     (period),
        .period_nxt_o (period_nxt),
        .rdata_o      (reg_rdata)
    );

    assign irq = to_flag & ie;

    // R12: clearing the timeout flag drops the interrupt
    a_r12_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(to_flag) |-> !irq);

    // R12: enabling with a pending timeout raises the interrupt
    a_r12_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ie) && to_flag |-> irq);

endmodule

// File: tb/ivl_timer_test.sv
module ivl_timer_test;

    localparam int AW = 5;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_STAT = 5'd0;
    localparam logic [AW-1:0] A_CTRL = 5'd4;
    localparam logic [AW-1:0] A_PLO  = 5'd8;
    localparam logic [AW-1:0] A_PHI  = 5'd12;
    localparam logic [AW-1:0] A_CLO  = 5'd16;
    localparam logic [AW-1:0] A_CHI  = 5'd20;
    localparam logic [DW-1:0] C_IE    = 32'h1;
    localparam logic [DW-1:0] C_CONT  = 32'h2;
    localparam logic [DW-1:0] C_START = 32'h4;
    localparam logic [DW-1:0] C_STOP  = 32'h8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;

    ivl_timer #(.ADDR_W(AW), .BUS_W(DW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // count after k steps from start with period p
    function automatic logic [DW-1:0] exp_count(input longint p, input longint k, input bit cont);
        if (cont) return DW'(p - (k % (p + 1)));
        return (k <= p) ? DW'(p - k) : DW'(p);
    endfunction

    // status word after k steps: bit0 timeout, bit1 running
    function automatic logic [DW-1:0] exp_status(input longint p, input longint k, input bit cont);
        logic to_f, run_f;
        to_f  = (k >= p + 1);
        run_f = cont ? 1'b1 : (k < p + 1);
        return {30'd0, run_f, to_f};
    endfunction

    task automatic load_period(input logic [DW-1:0] p);
        wr(A_CTRL, C_STOP);
        wr(A_PLO, {$urandom() & 32'hFFFF_0000} | {16'd0, p[15:0]});
        wr(A_PHI, {$urandom() & 32'hFFFF_0000} | {16'd0, p[31:16]});
        wr(A_STAT, $urandom());
    endtask

    task automatic run_case(input logic [DW-1:0] p, input int w, input bit cont, input bit ie);
        logic [DW-1:0] lo, hi, st;
        load_period(p);
        wr(A_CTRL, C_START | (cont ? C_CONT : 0) | (ie ? C_IE : 0));
        idle(w);
        wr(($urandom() & 1) ? A_CHI : A_CLO, $urandom());
        rd(A_CLO, lo);
        rd(A_CHI, hi);
        rd(A_STAT, st);
        check("R8/R9/R10/R11 capture", {hi[15:0], lo[15:0]}, exp_count(p, w, cont));
        check("R8/R9/R10 status", st, exp_status(p, w + 1, cont));
        check("R12 irq", {31'd0, irq}, {31'd0, exp_status(p, w + 1, cont)[0] & ie});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        for (int s = 0; s < 6; s++) chk_rd("R2 reset slot zero", AW'(s * 4), '0);
        check("R2 reset irq", {31'd0, irq}, '0);
        wr(A_CLO, '0);
        chk_rd("R2 reset count low", A_CLO, 32'h0000_FFFF);
        chk_rd("R2 reset count high", A_CHI, 32'h0000_FFFF);

        // R1: unmapped slots and ignored low address bits
        wr(5'd24, 32'hFFFF_FFFF);
        wr(5'd28, 32'hFFFF_FFFF);
        chk_rd("R1 slot6 reads zero", 5'd24, '0);
        chk_rd("R1 slot7 reads zero", 5'd29, '0);
        chk_rd("R1 unmapped write ignored ctrl", A_CTRL, '0);
        chk_rd("R1 unmapped write ignored plo", A_PLO, '0);
        chk_rd("R1 unmapped write ignored stat", A_STAT, '0);
        wr(5'd9, 32'h0000_0042);
        chk_rd("R1 low addr bits ignored", 5'd10, 32'h42);

        // R3 and R6: both strobes while stopped, stop wins
        wr(A_CTRL, 32'hFFFF_FFFF);
        chk_rd("R3 ctrl readback", A_CTRL, 32'h3);
        chk_rd("R6 start+stop stays stopped", A_STAT, '0);

        // R7: period halves masked, write loads count
        wr(A_PLO, 32'hABCD_0007);
        wr(A_PHI, 32'h1234_0000);
        chk_rd("R7 period low masked", A_PLO, 32'h7);
        chk_rd("R7 period high masked", A_PHI, 32'h0);
        wr(A_CHI, '0);
        chk_rd("R7 count loaded", A_CLO, 32'h7);

        // R7: period write while running halts and reloads
        load_period(32'd50);
        wr(A_CTRL, C_START | C_CONT);
        idle(2);
        wr(A_PLO, 32'hFFFF_0007);
        chk_rd("R7 period write stops", A_STAT, '0);
        wr(A_CLO, '0);
        chk_rd("R7 count takes new period", A_CLO, 32'h7);

        // R5: start while running has no effect
        load_period(32'd100);
        wr(A_CTRL, C_START | C_CONT);
        idle(2);
        wr(A_CTRL, C_START | C_CONT);
        wr(A_CLO, '0);
        chk_rd("R5 start while running keeps count", A_CLO, 32'd97);
        chk_rd("R5 still running", A_STAT, 32'h2);

        // R6: stop freezes after that cycle's step
        load_period(32'd100);
        wr(A_CTRL, C_START | C_CONT);
        idle(3);
        wr(A_CTRL, C_STOP | C_CONT);
        wr(A_CLO, '0);
        chk_rd("R6 stop count", A_CLO, 32'd96);
        idle(5);
        wr(A_CHI, '0);
        chk_rd("R6 frozen count", A_CLO, 32'd96);
        chk_rd("R6 stopped flag", A_STAT, '0);
        // R6: both strobes while running, stop wins
        wr(A_CTRL, C_START);
        wr(A_CTRL, C_START | C_STOP);
        chk_rd("R6 stop wins while running", A_STAT, '0);

        // R4: clear collides with timeout, then plain clear
        load_period(32'd3);
        wr(A_CTRL, C_START | C_CONT);
        idle(3);
        wr(A_STAT, '0);
        chk_rd("R4 timeout beats clear", A_STAT, 32'h3);
        wr(A_STAT, 32'h0000_0000);
        chk_rd("R4 clear any data", A_STAT, 32'h2);

        // R12: irq follows enable and flag
        load_period(32'd1);
        wr(A_CTRL, C_START);
        idle(4);
        chk_rd("R10 one-shot done", A_STAT, 32'h1);
        check("R12 irq masked", {31'd0, irq}, '0);
        wr(A_CTRL, C_IE);
        check("R12 irq on enable", {31'd0, irq}, 32'h1);
        wr(A_STAT, 32'h1234_5678);
        check("R12 irq on clear", {31'd0, irq}, '0);
        wr(A_CLO, '0);
        chk_rd("R10 holds period", A_CLO, 32'h1);

        // R8, R9, R10, R11: zero period and random cases
        run_case(32'd0, 0, 1'b0, 1'b1);
        run_case(32'd0, 5, 1'b1, 1'b1);
        for (int i = 0; i < 60; i++) begin
            logic [DW-1:0] p;
            int w;
            bit c, e;
            if ($urandom() % 4 == 0) p = {14'd0, 2'($urandom() % 3 + 1), 16'($urandom())};
            else p = DW'($urandom() % 41);
            w = int'($urandom() % 100);
            c = 1'($urandom());
            e = 1'($urandom());
            run_case(p, w, c, e);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule